// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a quad-data-rate static RAM. A host shares one single-rate address bus between reads and writes and selects the operation with two active-low strobes. Write data enters on its own port and read data leaves on another. Both ports carry two words per interface cycle, so every access moves a four-word burst in two interface cycles. A burst is held as one wide entry, and each written word carries its own per-byte enables.

The model runs on a clock at twice the interface rate. An internal phase bit marks each fast cycle as the rising or the falling half of an interface cycle, and the `rise_slot` output shows that phase. Commands are taken only at the fast edge that closes a rising slot (a command edge). Address decode is done at the burst level. The block resolves clashing requests, drops a repeat of the same kind on the next command edge, and signals an undriven read port through an enable flag.

Top module: `qdr_burst4_sram`

## Requirements
- R1: After reset `rise_slot` is 1, and it toggles on every clock. `rd_n` and `wr_n` are acted on only at an edge where `rise_slot` was 1 (a command edge). A select asserted at any other edge has no effect.
- R2: A read accepted at command edge t returns the stored burst. Word k (bits [k*DW +: DW] of the entry, k = 0..3) is on `rdata` in the cycle after edge t+RD_LAT+k. With RD_LAT = 3, word 0 falls in a cycle where `rise_slot` is 1.
- R3: A write accepted at command edge t takes word k from `wdata` at edge t+2+k. That gives words 0 and 2 at rising slots and words 1 and 3 at falling slots. The burst is committed to the addressed entry at edge t+5.
- R4: Each write beat carries its own `wbe`. Bit j enables byte j (bits [8j+7:8j]) of that word, and a cleared bit keeps the stored byte. A beat with `wbe` all zero leaves that word unchanged.
- R5: A read requested at the command edge right after an accepted read is ignored, and the earlier burst completes. The same rule applies to writes.
- R6: A write is accepted only if `rd_n` is high at that edge. When both selects are low, the read is served and the write is dropped with no change to storage.
- R7: Reads and writes may alternate on consecutive command edges. After a command edge with no accepted request, either kind may be accepted.
- R8: `rdata_oe` is 1 exactly in the cycles that carry valid read words, so two reads four edges apart give an unbroken eight-cycle window. At all other times, including during and after reset, `rdata_oe` is 0 and `rdata` is all zero.
- R9: A read takes a snapshot of its entry at edge t+RD_LAT. A write that commits at that same edge is not visible to the read.
- R10: After reset, every entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the interface rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| addr | input | AW | Shared burst address |
| wdata | input | DW | Write data beat |
| wbe | input | DW/8 | Per-byte enables for the current write beat |
| rise_slot | output | 1 | 1 while the current fast cycle is a rising slot |
| rdata | output | DW | Read data beat, zero when not enabled |
| rdata_oe | output | 1 | Read port enable (0 means high impedance) |

## Verification
A read accepted at command edge t owns `rdata` in the cycles after edges t+3 through t+6. A write samples its beats at edges t+2 through t+5 and becomes readable by any read whose snapshot edge is t+6 or later. The bench reference model counts fast edges from reset release. It applies the acceptance rules at even edges, queues reads for snapshot at edge t+3 and writes for beat capture from edge t+2, and takes the snapshot before the commit when both fall on the same edge. Outputs are compared at every falling clock edge, so each beat is checked in the middle of the cycle it belongs to. Directed cases cover each timing rule, and a long random mix follows.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BURST = 4;
    localparam int BYTE_W = 8;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;
endpackage

// File: rtl/qdr_store.sv
module qdr_store #(
    parameter int AW    = 4,
    parameter int ENT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    w_addr,
    input  logic [ENT_W-1:0] w_data,
    input  logic [AW-1:0]    mrg_addr,
    output logic [ENT_W-1:0] mrg_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [ENT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [ENT_W-1:0] mem_q [DEPTH];

    assign mrg_data = mem_q[mrg_addr];
    assign rd_data  = mem_q[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[w_addr] <= w_data;
        end
    end
endmodule

// File: rtl/qdr_arb.sv
module qdr_arb
    import qdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rise_slot,
    output logic rd_go,
    output logic wr_go
);
    typedef struct packed {
        phase_e ph;
        logic   rd_last;
        logic   wr_last;
    } arb_t;

    arb_t st_q, st_d;
    logic cmd_edge;

    always_comb begin
        st_d      = st_q;
        cmd_edge  = (st_q.ph == PH_RISE);
        rise_slot = cmd_edge;
        rd_go     = cmd_edge && !rd_n && !st_q.rd_last;
        wr_go     = cmd_edge && !wr_n && rd_n && !st_q.wr_last;
        st_d.ph   = (st_q.ph == PH_RISE) ? PH_FALL : PH_RISE;
        if (cmd_edge) begin
            st_d.rd_last = rd_go;
            st_d.wr_last = wr_go;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_RISE, rd_last: 1'b0, wr_last: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qdr_wr_path.sv
module qdr_wr_path
    import qdr_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_go,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic [DW/8-1:0]     wbe,
    output logic [AW-1:0]       mem_addr,
    input  logic [BURST*DW-1:0] mem_old,
    output logic                mem_we,
    output logic [BURST*DW-1:0] mem_new
);
    localparam int NB    = DW / BYTE_W;
    localparam int ENT_W = BURST * DW;
    localparam int LANES = BURST * NB;
    localparam int BCW   = $clog2(BURST);

    typedef struct packed {
        logic [1:0]         dv;
        logic [1:0][AW-1:0] da;
        logic               act;
        logic [BCW-1:0]     bcnt;
        logic [AW-1:0]      wadr;
        logic [ENT_W-1:0]   wbuf;
        logic [LANES-1:0]   msk;
    } wr_t;

    wr_t st_q, st_d;
    logic [BCW-1:0] idx;

    always_comb begin
        st_d       = st_q;
        mem_we     = 1'b0;
        st_d.dv    = {st_q.dv[0], wr_go};
        st_d.da[0] = addr;
        st_d.da[1] = st_q.da[0];
        idx        = st_q.dv[1] ? '0 : st_q.bcnt;
        if (st_q.dv[1]) st_d.wadr = st_q.da[1];
        if (st_q.dv[1] || st_q.act) begin
            st_d.wbuf[int'(idx)*DW +: DW] = wdata;
            st_d.msk[int'(idx)*NB +: NB]  = wbe;
            if (int'(idx) == BURST - 1) begin
                mem_we   = 1'b1;
                st_d.act = 1'b0;
            end else begin
                st_d.act  = 1'b1;
                st_d.bcnt = idx + 1'b1;
            end
        end
        mem_addr = st_q.wadr;
        for (int i = 0; i < LANES; i++) begin
            mem_new[i*BYTE_W +: BYTE_W] = st_d.msk[i] ? st_d.wbuf[i*BYTE_W +: BYTE_W]
                                                      : mem_old[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path
    import qdr_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int RL = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_go,
    input  logic [AW-1:0]       addr,
    output logic [AW-1:0]       mem_addr,
    input  logic [BURST*DW-1:0] mem_data,
    output logic [DW-1:0]       rdata,
    output logic                rdata_oe
);
    localparam int ENT_W = BURST * DW;
    localparam int LW    = $clog2(BURST + 1);

    typedef struct packed {
        logic [RL-1:0]         pv;
        logic [RL-1:0][AW-1:0] pa;
        logic [LW-1:0]         left;
        logic [ENT_W-1:0]      words;
    } rd_t;

    rd_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.pv[0] = rd_go;
        st_d.pa[0] = addr;
        for (int i = 1; i < RL; i++) begin
            st_d.pv[i] = st_q.pv[i-1];
            st_d.pa[i] = st_q.pa[i-1];
        end
        mem_addr = st_q.pa[RL-1];
        if (st_q.pv[RL-1]) begin
            st_d.words = mem_data;
            st_d.left  = LW'(BURST);
        end else if (st_q.left != '0) begin
            st_d.words = st_q.words >> DW;
            st_d.left  = st_q.left - 1'b1;
        end
        rdata_oe = (st_q.left != '0);
        rdata    = rdata_oe ? st_q.words[DW-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qdr_burst4_sram.sv
module qdr_burst4_sram
    import qdr_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 16,
    parameter int RD_LAT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] wbe,
    output logic            rise_slot,
    output logic [DW-1:0]   rdata,
    output logic            rdata_oe
);
    localparam int ENT_W = BURST * DW;

    logic             rd_go, wr_go, mem_we;
    logic [AW-1:0]    w_addr, r_addr;
    logic [ENT_W-1:0] old_ent, new_ent, rd_ent;

    qdr_arb u_arb (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
        .rise_slot(rise_slot), .rd_go(rd_go), .wr_go(wr_go)
    );

    qdr_wr_path #(.AW(AW), .DW(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .addr(addr),
        .wdata(wdata), .wbe(wbe), .mem_addr(w_addr), .mem_old(old_ent),
        .mem_we(mem_we), .mem_new(new_ent)
    );

    qdr_rd_path #(.AW(AW), .DW(DW), .RL(RD_LAT)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .addr(addr),
        .mem_addr(r_addr), .mem_data(rd_ent), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    qdr_store #(.AW(AW), .ENT_W(ENT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .w_addr(w_addr), .w_data(new_ent),
        .mrg_addr(w_addr), .mrg_data(old_ent), .rd_addr(r_addr), .rd_data(rd_ent)
    );
endmodule

// File: rtl/qdr_burst4_sram_chk.sv
module qdr_burst4_sram_chk #(
    parameter int RL = 3,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_n,
    input logic          rise_slot,
    input logic          rdata_oe,
    input logic [DW-1:0] rdata,
    input logic          rd_go,
    input logic          wr_go
);
    logic [7:0] since_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rd <= 8'hff;
        else if (rd_go)          since_rd <= 8'd0;
        else if (since_rd != 8'hff) since_rd <= since_rd + 8'd1;
    end

    // R1
    phase_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) rise_slot |=> !rise_slot);
    // R1
    phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) !rise_slot |=> rise_slot);
    // R1
    cmd_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_go || wr_go) |-> rise_slot);
    // R5
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_go |=> ##1 !rd_go);
    // R5
    wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> ##1 !wr_go);
    // R6
    rd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_go |-> rd_n);
    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdata_oe) |-> (since_rd == 8'(RL)));
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !rdata_oe |-> (rdata == '0));
endmodule

bind qdr_burst4_sram qdr_burst4_sram_chk #(.RL(RD_LAT), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rise_slot(rise_slot),
    .rdata_oe(rdata_oe), .rdata(rdata), .rd_go(rd_go), .wr_go(wr_go)
);

// File: tb/qdr_burst4_sram_test.sv
module qdr_burst4_sram_test;
    localparam int AW = 4, DW = 16, NB = 2, RL = 3, EW = 64;

    logic clk = 1'b0, rst_n = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] wbe = '1;
    logic rise_slot, rdata_oe;
    logic [DW-1:0] rdata;

    always #2 clk = ~clk;

    qdr_burst4_sram uut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .wbe(wbe), .rise_slot(rise_slot), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R8";

    bit sch_r[int];
    bit sch_w[int];
    logic [AW-1:0] sch_a[int];
    logic [DW-1:0] sch_d[int];
    logic [NB-1:0] sch_m[int];

    int en = 0;
    logic [EW-1:0] mm [16];
    bit rlast = 0, wlast = 0;
    int rq_e[$];
    logic [AW-1:0] rq_a[$];
    int wq_e[$];
    logic [AW-1:0] wq_a[$];
    logic [EW-1:0] ow = '0, wb = '0;
    logic [4*NB-1:0] wm = '0;
    int oidx = 0, ocnt = 0;

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: got %h expected %h", req, what, en, act, exp);
        end
    endtask

    // reference model, one step per clock edge after reset release
    always @(posedge clk) begin
        if (rst_n) begin
            if (ocnt > 0) begin oidx++; ocnt--; end
            if (rq_e.size() > 0 && rq_e[0] == en) begin
                ow = mm[rq_a[0]]; oidx = 0; ocnt = 4;
                void'(rq_e.pop_front()); void'(rq_a.pop_front());
            end
            if (wq_e.size() > 0 && en >= wq_e[0] && en <= wq_e[0] + 3) begin
                int b;
                b = en - wq_e[0];
                wb[b*DW +: DW] = wdata;
                wm[b*NB +: NB] = wbe;
                if (b == 3) begin
                    for (int i = 0; i < 4*NB; i++)
                        if (wm[i]) mm[wq_a[0]][i*8 +: 8] = wb[i*8 +: 8];
                    void'(wq_e.pop_front()); void'(wq_a.pop_front());
                end
            end
            if (en % 2 == 0) begin
                bit racc, wacc;
                racc = !rd_n && !rlast;
                wacc = !wr_n && rd_n && !wlast;
                rlast = racc; wlast = wacc;
                if (racc) begin rq_e.push_back(en + RL); rq_a.push_back(addr); end
                if (wacc) begin wq_e.push_back(en + 2); wq_a.push_back(addr); end
            end
            en++;
        end
    end

    // compare outputs mid-cycle, then drive inputs for the next edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "rdata_oe", DW'(rdata_oe), DW'(ocnt > 0));
            chk(cur_req, "rdata", rdata, (ocnt > 0) ? ow[oidx*DW +: DW] : '0);
            chk("R1", "rise_slot", DW'(rise_slot), DW'(en % 2 == 0));
            rd_n  = !sch_r.exists(en);
            wr_n  = !sch_w.exists(en);
            addr  = sch_a.exists(en) ? sch_a[en] : '0;
            wdata = sch_d.exists(en) ? sch_d[en] : DW'(en * 37 + 5);
            wbe   = sch_m.exists(en) ? sch_m[en] : '1;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic next_base(output int b);
        b = en + 2;
        if (b % 2 != 0) b++;
    endtask

    task automatic rd_cmd(int e, logic [AW-1:0] a);
        sch_r[e] = 1; sch_a[e] = a;
    endtask

    task automatic wr_cmd(int e, logic [AW-1:0] a, logic [EW-1:0] d, logic [4*NB-1:0] m);
        sch_w[e] = 1; sch_a[e] = a;
        for (int k = 0; k < 4; k++) begin
            sch_d[e+2+k] = d[k*DW +: DW];
            sch_m[e+2+k] = m[k*NB +: NB];
        end
    endtask

    initial begin
        int b;
        for (int i = 0; i < 16; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        chk("R8", "rdata_oe in reset", DW'(rdata_oe), '0);
        chk("R8", "rdata in reset", rdata, '0);
        chk("R1", "rise_slot in reset", DW'(rise_slot), 16'd1);
        @(negedge clk); #1 rst_n = 1'b1;
        run(2);
        chk("R8", "rdata_oe after reset", DW'(rdata_oe), '0);

        // R10: untouched entry reads zero
        cur_req = "R10"; next_base(b);
        rd_cmd(b, 3); run(16);

        // R2 / R3: full write then read back
        cur_req = "R3"; next_base(b);
        wr_cmd(b, 1, 64'h1111_2222_3333_4444, 8'hff);
        rd_cmd(b + 8, 1); run(20);

        // R4: per-beat byte masks, beat 2 fully blocked
        cur_req = "R4"; next_base(b);
        wr_cmd(b, 1, 64'hAAAA_BBBB_CCCC_DDDD, 8'b01_00_10_11);
        rd_cmd(b + 8, 1); run(20);

        // R5: repeated read and repeated write on next command edge
        cur_req = "R5"; next_base(b);
        rd_cmd(b, 1); rd_cmd(b + 2, 2);
        wr_cmd(b + 10, 6, 64'h6666_6161_6262_6363, 8'hff);
        wr_cmd(b + 12, 7, 64'h7777_7171_7272_7373, 8'hff);
        rd_cmd(b + 24, 7); rd_cmd(b + 28, 6); run(40);

        // R6: both selects together, read wins
        cur_req = "R6"; next_base(b);
        rd_cmd(b, 8); wr_cmd(b, 8, 64'h8888_8181_8282_8383, 8'hff);
        rd_cmd(b + 8, 8); run(20);

        // R9: read snapshot on the same edge the write commits
        cur_req = "R9"; next_base(b);
        wr_cmd(b, 4, 64'h4444_4141_4242_4343, 8'hff);
        rd_cmd(b + 2, 4); rd_cmd(b + 6, 4); run(20);

        // R7: alternating kinds and restart after idle
        cur_req = "R7"; next_base(b);
        wr_cmd(b, 5, 64'h5555_5151_5252_5353, 8'hff);
        rd_cmd(b + 2, 4);
        wr_cmd(b + 4, 9, 64'h9999_9191_9292_9393, 8'hff);
        rd_cmd(b + 6, 5);
        rd_cmd(b + 10, 9);
        wr_cmd(b + 12, 5, 64'h0f0f_f0f0_1234_5678, 8'hff);
        rd_cmd(b + 16, 5); run(30);

        // R1: select held only at a falling-slot edge is ignored
        cur_req = "R1"; next_base(b);
        rd_cmd(b + 1, 1); wr_cmd(b + 1, 2, 64'hdead_beef_dead_beef, 8'hff);
        rd_cmd(b + 10, 2); run(24);

        // R8: reads four edges apart keep the port enabled without a gap
        cur_req = "R8"; next_base(b);
        rd_cmd(b, 1); rd_cmd(b + 4, 6); run(20);

        // R2: random mixed traffic
        cur_req = "R2"; next_base(b);
        for (int k = 0; k < 300; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            if ($urandom % 3 == 0) rd_cmd(b + 2*k, a);
            if ($urandom % 2 == 0) wr_cmd(b + 2*k, a, {$urandom, $urandom}, 8'($urandom));
        end
        run(640);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule